// File: doc/BRIEF.md
# Pulse Processor Phase Sequencer

This block drives the control strobes of a switched-capacitor three-weight filter that follows an analogue sample pipeline. A readout controller sends a one-cycle start request and a mode bit. The sequencer then runs one of two fixed strobe programs. In the deconvolution program, three stored samples are read one at a time, the three weighted charges are summed, and the result is captured by a hold-store strobe. In the peak program, one sample is read, the amplifier reset level is taken in place of a second sample, two weighted charges are summed, and the result is stored.

Every strobe is active low and rests high. Each strobe pulse lasts `PULSE_CYCLES` clocks, and `GAP_CYCLES` idle clocks follow each pulse so that no two phase strobes are ever low together. A separate gain-reduce strobe enlarges the feedback capacitance while the charges are summed. A `busy` flag covers the whole program, and a one-cycle `done` pulse lets the controller line the store phase up with its output header period.

Top module: `phaseSeqTop`

## Requirements
- R1: After reset, all eight strobes (`readN`, `sumN`, `gainRedN`, `storeN`) are high, and `busy` and `done` are low.
- R2: With `peakMode` low when start is accepted, the strobes go low in this order: `readN[0]`, `readN[1]`, `readN[2]`, `sumN[0]`, `sumN[1]`, `sumN[2]`, `storeN`. Each stays low for `PULSE_CYCLES` cycles and is followed by `GAP_CYCLES` cycles with all of them high. `readN[0]` is low in the first cycle after the clock edge that samples start.
- R3: At most one of the seven read, sum and store strobes is low in any cycle.
- R4: In the deconvolution program, `gainRedN` is low exactly in the cycles in which one of the `sumN` bits is low.
- R5: With `peakMode` high when start is accepted, the order is `readN[0]` (sample), `readN[1]` (reset level), `sumN[0]`, `sumN[1]`, `storeN`, with the same pulse and gap timing. `readN[2]` and `sumN[2]` stay high.
- R6: In the peak program, `gainRedN` is low without a break from the first cycle of `sumN[0]` through the last cycle of `sumN[1]`, including the gap between the two.
- R7: `done` is high for exactly one cycle: the first cycle after `storeN` returns high.
- R8: `busy` is high from the first strobe cycle through the last gap cycle after the store. A start request while `busy` is high is ignored.
- R9: The mode is sampled only when start is accepted. Changes on `peakMode` during a program do not alter it.
- R10: A start request in the first cycle with `busy` low is accepted, and the next program begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per sample period |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run one program; accepted only while idle |
| peakMode | input | 1 | 1 selects the peak program, 0 the deconvolution program |
| readN | output | 3 | Read strobes 1..3 (bit 0 = first), active low |
| sumN | output | 3 | Sum strobes 1..3 (bit 0 = first), active low |
| gainRedN | output | 1 | Gain-reduce strobe for summing, active low |
| storeN | output | 1 | Hold-store strobe, active low |
| busy | output | 1 | A program is in progress |
| done | output | 1 | One-cycle pulse after the store strobe is released |

## Verification
The checker tests these properties on every cycle:
- The read, sum and store strobes never overlap.
- The gain-reduce strobe never coincides with a read or store strobe.
- The gain-reduce strobe stays low across the peak-mode summing gap.
- An accepted start drops the first read strobe in the next cycle.
- `done` is a single cycle that follows a store.

Only the bench scenarios can show the rest:
- The full phase order and duration of each program.
- That the mode is held against input changes.
- That start requests made while busy are dropped.
- That a request in the first idle cycle is taken.

The bench compares every output in every cycle against a timeline it computes from the pulse and gap lengths.

// File: rtl/phaseSeqPkg.sv
package phaseSeqPkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RD1   = 3'd1,
    PH_RD2   = 3'd2,
    PH_RD3   = 3'd3,
    PH_SUM1  = 3'd4,
    PH_SUM2  = 3'd5,
    PH_SUM3  = 3'd6,
    PH_STORE = 3'd7
  } phaseT;

  // Active-high requests handed from control to the output register.
  typedef struct packed {
    logic [2:0] rd;
    logic [2:0] sum;
    logic       gain;
    logic       store;
    logic       busy;
    logic       done;
  } strobeT;

  // Phase that follows p in the program chosen by peak.
  function automatic phaseT nextPhase(input phaseT p, input logic peak);
    case (p)
      PH_RD1:  nextPhase = PH_RD2;
      PH_RD2:  nextPhase = peak ? PH_SUM1 : PH_RD3;
      PH_RD3:  nextPhase = PH_SUM1;
      PH_SUM1: nextPhase = PH_SUM2;
      PH_SUM2: nextPhase = peak ? PH_STORE : PH_SUM3;
      PH_SUM3: nextPhase = PH_STORE;
      default: nextPhase = PH_IDLE;
    endcase
  endfunction

  function automatic phaseT readPhaseOf(input int idx);
    case (idx)
      0:       readPhaseOf = PH_RD1;
      1:       readPhaseOf = PH_RD2;
      default: readPhaseOf = PH_RD3;
    endcase
  endfunction

  function automatic phaseT sumPhaseOf(input int idx);
    case (idx)
      0:       sumPhaseOf = PH_SUM1;
      1:       sumPhaseOf = PH_SUM2;
      default: sumPhaseOf = PH_SUM3;
    endcase
  endfunction

endpackage

// File: rtl/phaseSeqCtrl.sv
module phaseSeqCtrl
  import phaseSeqPkg::*;
#(
  parameter int PULSE_CYCLES = 1,
  parameter int GAP_CYCLES   = 1,
  parameter int NUM_STROBES  = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   peakMode,
  output strobeT strobeNext
);

  localparam int CNT_MAX = (PULSE_CYCLES > GAP_CYCLES) ? PULSE_CYCLES : GAP_CYCLES;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYCLES - 1);

  phaseT            phaseQ, phaseN;
  logic             gapQ, gapN;
  logic             peakQ, peakN;
  logic [CNT_W-1:0] cntQ, cntN;

  // Next-state: idle waits for start; otherwise count pulse, then gap.
  always_comb begin
    phaseN = phaseQ;
    gapN   = gapQ;
    peakN  = peakQ;
    cntN   = cntQ;
    if (phaseQ == PH_IDLE) begin
      if (start) begin
        phaseN = PH_RD1;
        gapN   = 1'b0;
        cntN   = '0;
        peakN  = peakMode;
      end
    end else if (!gapQ) begin
      if (cntQ == PULSE_LAST) begin
        gapN = 1'b1;
        cntN = '0;
      end else begin
        cntN = cntQ + 1'b1;
      end
    end else begin
      if (cntQ == GAP_LAST) begin
        phaseN = nextPhase(phaseQ, peakQ);
        gapN   = 1'b0;
        cntN   = '0;
      end else begin
        cntN = cntQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      gapQ   <= 1'b0;
      peakQ  <= 1'b0;
      cntQ   <= '0;
    end else begin
      phaseQ <= phaseN;
      gapQ   <= gapN;
      peakQ  <= peakN;
      cntQ   <= cntN;
    end
  end

  // Decode from next state so the registered strobes line up with it.
  logic                   pulseN;
  logic [NUM_STROBES-1:0] rdReq, sumReq;

  assign pulseN = !gapN && (phaseN != PH_IDLE);

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_req
    assign rdReq[i]  = pulseN && (phaseN == readPhaseOf(i));
    assign sumReq[i] = pulseN && (phaseN == sumPhaseOf(i));
  end

  always_comb begin
    strobeNext       = '0;
    strobeNext.rd    = rdReq;
    strobeNext.sum   = sumReq;
    strobeNext.store = pulseN && (phaseN == PH_STORE);
    strobeNext.busy  = (phaseN != PH_IDLE);
    strobeNext.done  = (phaseN == PH_STORE) && gapN && (cntN == '0);
    if (peakN)
      strobeNext.gain = (phaseN == PH_SUM1) || ((phaseN == PH_SUM2) && pulseN);
    else
      strobeNext.gain = |sumReq;
  end

endmodule

// File: rtl/phaseSeqStrobeReg.sv
module phaseSeqStrobeReg
  import phaseSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     strobeNext,
  output logic [2:0] readN,
  output logic [2:0] sumN,
  output logic       gainRedN,
  output logic       storeN,
  output logic       busy,
  output logic       done
);

  strobeT strobeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeQ <= '0;
    else       strobeQ <= strobeNext;
  end

  assign readN    = ~strobeQ.rd;
  assign sumN     = ~strobeQ.sum;
  assign gainRedN = ~strobeQ.gain;
  assign storeN   = ~strobeQ.store;
  assign busy     = strobeQ.busy;
  assign done     = strobeQ.done;

endmodule

// File: rtl/phaseSeqTop.sv
module phaseSeqTop
  import phaseSeqPkg::*;
#(
  parameter int PULSE_CYCLES = 1,
  parameter int GAP_CYCLES   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       peakMode,
  output logic [2:0] readN,
  output logic [2:0] sumN,
  output logic       gainRedN,
  output logic       storeN,
  output logic       busy,
  output logic       done
);

  strobeT strobeNext;

  phaseSeqCtrl #(
    .PULSE_CYCLES(PULSE_CYCLES),
    .GAP_CYCLES  (GAP_CYCLES),
    .NUM_STROBES (3)
  ) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .peakMode  (peakMode),
    .strobeNext(strobeNext)
  );

  phaseSeqStrobeReg outReg (
    .clk       (clk),
    .rstN      (rstN),
    .strobeNext(strobeNext),
    .readN     (readN),
    .sumN      (sumN),
    .gainRedN  (gainRedN),
    .storeN    (storeN),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: rtl/phaseSeqChk.sv
module phaseSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [2:0] readN,
  input logic [2:0] sumN,
  input logic       gainRedN,
  input logic       storeN,
  input logic       busy,
  input logic       done
);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~{readN, sumN, storeN}));

  // R4
  gain_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gainRedN |-> (busy && (&readN) && storeN));

  // R6
  gain_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gainRedN && (&sumN)) |=> !gainRedN);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_after_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(storeN) == 1'b0 && storeN && busy));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && !readN[0]));

endmodule

bind phaseSeqTop phaseSeqChk chkInst (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .readN   (readN),
  .sumN    (sumN),
  .gainRedN(gainRedN),
  .storeN  (storeN),
  .busy    (busy),
  .done    (done)
);

// File: tb/tb_phaseSeqTop.sv
module tb_phaseSeqTop;

  localparam int PULSE = 1;
  localparam int GAP   = 1;
  localparam int PER   = PULSE + GAP;

  logic       clk = 1'b0;
  logic       rstN;
  logic       start;
  logic       peakMode;
  logic [2:0] readN;
  logic [2:0] sumN;
  logic       gainRedN;
  logic       storeN;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  phaseSeqTop #(.PULSE_CYCLES(PULSE), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .peakMode(peakMode),
    .readN(readN), .sumN(sumN), .gainRedN(gainRedN), .storeN(storeN),
    .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected outputs in cycle k of a program (k counted from the first strobe cycle).
  task automatic checkCycle(input bit pk, input int k, input string extra);
    int         nph  = pk ? 5 : 7;
    int         len  = nph * PER;
    logic [2:0] eRd  = 3'b111;
    logic [2:0] eSum = 3'b111;
    logic       eGain = 1'b1, eStore = 1'b1, eBusy = 1'b0, eDone = 1'b0;
    string      ordTag  = pk ? "R5" : "R2";
    string      gainTag = pk ? "R6" : "R4";
    if (k < len) begin
      int ph    = k / PER;
      int off   = k % PER;
      bit pulse = off < PULSE;
      eBusy = 1'b1;
      eDone = (ph == nph - 1) && (off == PULSE);
      if (pk) begin
        if (pulse) begin
          case (ph)
            0: eRd[0] = 1'b0;
            1: eRd[1] = 1'b0;
            2: eSum[0] = 1'b0;
            3: eSum[1] = 1'b0;
            default: eStore = 1'b0;
          endcase
        end
        eGain = !((ph == 2) || (ph == 3 && pulse));
      end else begin
        if (pulse) begin
          if (ph < 3) eRd[ph] = 1'b0;
          else if (ph < 6) eSum[ph-3] = 1'b0;
          else eStore = 1'b0;
        end
        eGain = !(pulse && ph >= 3 && ph <= 5);
      end
    end
    chk({ordTag, " read", extra}, {5'd0, readN}, {5'd0, eRd});
    chk({ordTag, " sum", extra}, {5'd0, sumN}, {5'd0, eSum});
    chk({ordTag, " store", extra}, {7'd0, storeN}, {7'd0, eStore});
    chk({gainTag, " gain", extra}, {7'd0, gainRedN}, {7'd0, eGain});
    chk({"R7 done", extra}, {7'd0, done}, {7'd0, eDone});
    chk({"R8 busy", extra}, {7'd0, busy}, {7'd0, eBusy});
    chk({"R3 overlap", extra}, 8'($countones(~{readN, sumN, storeN}) > 1), 8'd0);
  endtask

  task automatic runSeq(input bit pk, input bit wig, input bit junk,
                        input bit chain, input bit launched, input string extra);
    int len  = (pk ? 5 : 7) * PER;
    int last = chain ? len : len + 1;
    if (!launched) begin
      @(negedge clk);
      start    = 1'b1;
      peakMode = pk;
    end
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      checkCycle(pk, k, extra);
      if (chain && k == len) begin
        start    = 1'b1;
        peakMode = ~pk;
      end else begin
        start    = junk && (k < len);
        peakMode = wig ? ~peakMode : pk;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; peakMode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {readN, sumN, gainRedN, storeN}, 8'hFF);
    chk("R1 flags", {6'd0, busy, done}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {readN, sumN, gainRedN, storeN}, 8'hFF);

    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int j = 0; j < 2; j++)
          runSeq(m[0], w[0], j[0], 1'b0, 1'b0,
                 {(w != 0) ? " R9" : "", (j != 0) ? " R8 ignored" : ""});

    // R10: back-to-back programs, deconvolution then peak, then peak then deconvolution
    runSeq(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, " R10 first");
    runSeq(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, " R10 second");
    runSeq(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, " R10 third");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule